// File: doc/BRIEF.md
# Macrocell Storage and Output Stage

This block is the back end of one cell of a programmable logic array. It takes the sum-of-products result (the XOR output), a spare product term and the pad input. Configuration inputs choose which of the three feeds the storage element, and how that element behaves: an edge-triggered D, toggle, JK or set/reset cell, or a level-sensitive transparent latch. The same element drives the pad, the pad enable and the buried feedback that returns to the routing array.

The block runs from one system clock. The cell clocks are the global clock lines and a product-term clock. They are treated as level signals that are sampled on every system clock edge, and a cell clock edge is a low-to-high change between two samples. A product-term clock enable can gate the global clocks only. Asynchronous clear and preset act on the visible state in the same cycle they are raised, without waiting for any clock. The pad output and the feedback path each choose between the stored value and the raw XOR result, and each makes that choice on its own. The pad enable has five possible sources: off, on, either of two dedicated pins, or a product term.

Top module: `mc_regout`

## Requirements
- R1: A synchronous active-high `rst` clears the stored state to 0 on the next system clock edge, and this holds whatever the configuration is.
- R2: `cfg_dsrc` selects the data feeding the storage element: 0 = `xor_in`, 1 = `pt_d`, 2 = `pad_in`, 3 = `xor_in`.
- R3: With `cfg_mode` 0 (D), the state takes the data on a rising edge of the selected cell clock. Between edges the state holds.
- R4: With `cfg_mode` 1 (toggle), a cell-clock edge inverts the state when the data is 1 and leaves it unchanged when the data is 0.
- R5: With `cfg_mode` 2 (JK), the data is J and `pt_k` is K. On an edge, 00 holds, 10 sets, 01 clears and 11 toggles.
- R6: With `cfg_mode` 3 (set/reset), the data is S and `pt_k` is R. On an edge, 10 sets, 01 clears, and both 00 and 11 hold.
- R7: With `cfg_mode` 4 (latch), the stored value follows the data in the same cycle while the selected clock level is high. After the level falls, it keeps the last value it held.
- R8: `cfg_clk_sel` 0..2 selects `gclk[0..2]` and 3 selects `pt_clk`. Edges on clocks that are not selected have no effect.
- R9: With `cfg_ce_en`=1 and a global clock selected, edges are ignored while `pt_ce` is 0. With `pt_clk` selected, `pt_ce` has no effect.
- R10: `cfg_ar_sel` picks the asynchronous clear: 0 none, 1 `gclr`, 2 `pt_ar`, 3 the OR of both. An active clear forces the value to 0 in the same cycle and wins over preset.
- R11: `cfg_ap_sel`=1 lets `pt_ap` force the value to 1 in the same cycle. With `cfg_ap_sel`=0, `pt_ap` has no effect.
- R12: `pad_o` is the stored value when `cfg_out_reg`=1 and is `xor_in` otherwise. `fb_o` follows the same rule using `cfg_fb_reg`, independently of `cfg_out_reg`.
- R13: `cfg_oe_sel` gives `pad_oe`: 0 off, 1 on, 2 `oe_pin[0]`, 3 `oe_pin[1]`, 4 `pt_oe`, and 5..7 off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xor_in | input | 1 | Sum term after the XOR gate |
| pt_d | input | 1 | Spare product term used as data |
| pad_in | input | 1 | Pad input value |
| pt_k | input | 1 | Second operand (K or R) |
| gclk | input | NUM_GCLK (3) | Global clock levels |
| pt_clk | input | 1 | Product-term clock level |
| pt_ce | input | 1 | Product-term clock enable |
| gclr | input | 1 | Global clear |
| pt_ar | input | 1 | Product-term clear |
| pt_ap | input | 1 | Product-term preset |
| oe_pin | input | NUM_OE (2) | Dedicated enable pins |
| pt_oe | input | 1 | Product-term output enable |
| cfg_dsrc | input | 2 | Data source select |
| cfg_mode | input | 3 | Storage mode |
| cfg_clk_sel | input | CSEL_W (2) | Cell clock select |
| cfg_ce_en | input | 1 | Enable clock gating by pt_ce |
| cfg_ar_sel | input | 2 | Clear source select |
| cfg_ap_sel | input | 1 | Preset source select |
| cfg_out_reg | input | 1 | Pad takes the stored value |
| cfg_fb_reg | input | 1 | Feedback takes the stored value |
| cfg_oe_sel | input | OE_W (3) | Pad enable source |
| pad_o | output | 1 | Pad data |
| pad_oe | output | 1 | Pad enable |
| fb_o | output | 1 | Buried feedback |

## Verification
Three results are combinational and are due in the same cycle as their inputs: the pad enable, the combinational pad and feedback paths, and the effect of a clear, a preset or an open latch. The bench reads these one time unit after it drives the inputs. A cell-clock edge is seen at the first system clock edge after the clock level rises, and the new state shows on the pads just after that edge. The bench raises a clock level between edges and reads two time units after the next edge. Holds are read again one edge later, so a hold is also proven on the stored value and not only on the forced output.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        DS_XOR   = 2'd0,
        DS_PTERM = 2'd1,
        DS_PAD   = 2'd2,
        DS_ALT   = 2'd3
    } mc_dsrc_e;

    typedef enum logic [2:0] {
        MD_D     = 3'd0,
        MD_T     = 3'd1,
        MD_JK    = 3'd2,
        MD_SR    = 3'd3,
        MD_LATCH = 3'd4
    } mc_mode_e;

    typedef enum logic [1:0] {
        AR_NONE   = 2'd0,
        AR_GLOBAL = 2'd1,
        AR_PTERM  = 2'd2,
        AR_BOTH   = 2'd3
    } mc_ar_e;

    typedef struct packed {
        logic clr;
        logic set;
    } mc_async_t;

    typedef struct packed {
        logic rise;
        logic open;
    } mc_clkev_t;

    // Next state for the edge-triggered modes.
    function automatic logic mc_next(input mc_mode_e m, input logic q,
                                     input logic a, input logic b);
        logic r;
        case (m)
            MD_T:    r = q ^ a;
            MD_JK:   r = (a & ~q) | (~b & q);
            MD_SR: begin
                if (a && !b)      r = 1'b1;
                else if (!a && b) r = 1'b0;
                else              r = q;
            end
            default: r = a;
        endcase
        return r;
    endfunction

    function automatic logic mc_pick_data(input mc_dsrc_e s, input logic x,
                                          input logic p, input logic pad);
        logic r;
        case (s)
            DS_PTERM: r = p;
            DS_PAD:   r = pad;
            default:  r = x;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mc_clkgate.sv
module mc_clkgate
    import mc_pkg::*;
#(
    parameter int NUM_GCLK = 3,
    parameter int CSEL_W   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic [CSEL_W-1:0]   clk_sel,
    input  logic                ce_en,
    input  logic                pt_ce,
    output mc_clkev_t           ev
);
    localparam int NCLK = NUM_GCLK + 1;

    logic [NCLK-1:0] level;
    logic [NCLK-1:0] prev_q;
    logic [NCLK-1:0] rise;
    logic            sel_level;
    logic            sel_rise;
    logic            is_global;
    logic            gate_ok;

    assign level = {pt_clk, gclk};

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    generate
        for (genvar i = 0; i < NCLK; i++) begin : g_edge
            assign rise[i] = level[i] & ~prev_q[i];
        end
    endgenerate

    always_comb begin
        sel_level = 1'b0;
        sel_rise  = 1'b0;
        for (int i = 0; i < NCLK; i++) begin
            if (clk_sel == CSEL_W'(i)) begin
                sel_level = level[i];
                sel_rise  = rise[i];
            end
        end
    end

    assign is_global = (clk_sel < CSEL_W'(NUM_GCLK));
    assign gate_ok   = !(ce_en && is_global) || pt_ce;

    assign ev.rise = sel_rise & gate_ok;
    assign ev.open = sel_level & gate_ok;

    // A single rising level yields one edge while the select is steady.
    p_single_edge_r8: assert property (@(posedge clk) disable iff (rst)
        ev.rise |=> (!ev.rise || clk_sel != $past(clk_sel)));

endmodule

// File: rtl/mc_async.sv
module mc_async
    import mc_pkg::*;
(
    input  logic      gclr,
    input  logic      pt_ar,
    input  logic      pt_ap,
    input  logic [1:0] ar_sel,
    input  logic      ap_sel,
    output mc_async_t act
);
    mc_ar_e ar_mode;

    assign ar_mode = mc_ar_e'(ar_sel);

    always_comb begin
        case (ar_mode)
            AR_GLOBAL: act.clr = gclr;
            AR_PTERM:  act.clr = pt_ar;
            AR_BOTH:   act.clr = gclr | pt_ar;
            default:   act.clr = 1'b0;
        endcase
        act.set = ap_sel & pt_ap;
    end

endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic [2:0] mode,
    input  logic [1:0] dsrc,
    input  logic      xor_in,
    input  logic      pt_d,
    input  logic      pad_in,
    input  logic      pt_k,
    input  mc_clkev_t ev,
    input  mc_async_t asy,
    output logic      q
);
    mc_mode_e m;
    logic     d_sel;
    logic     latch_open;
    logic     state_q;
    logic     state_d;

    assign m          = mc_mode_e'(mode);
    assign d_sel      = mc_pick_data(mc_dsrc_e'(dsrc), xor_in, pt_d, pad_in);
    assign latch_open = (m == MD_LATCH) && ev.open;

    always_comb begin
        if (asy.clr)                        state_d = 1'b0;
        else if (asy.set)                   state_d = 1'b1;
        else if (latch_open)                state_d = d_sel;
        else if (ev.rise && m != MD_LATCH)  state_d = mc_next(m, state_q, d_sel, pt_k);
        else                                state_d = state_q;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= 1'b0;
        else     state_q <= state_d;
    end

    // Visible value: clear, then preset, then a transparent latch, then stored state.
    always_comb begin
        if (asy.clr)         q = 1'b0;
        else if (asy.set)    q = 1'b1;
        else if (latch_open) q = d_sel;
        else                 q = state_q;
    end

    p_sync_rst_r1: assert property (@(posedge clk)
        rst |=> !state_q);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ev.rise && !ev.open && !asy.clr && !asy.set) |=> $stable(state_q));

    p_jk_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (ev.rise && m == MD_JK && d_sel && pt_k && !asy.clr && !asy.set)
        |=> (state_q != $past(state_q)));

    p_latch_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (latch_open && !asy.clr && !asy.set) |=> (state_q == $past(d_sel)));

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (asy.clr && asy.set) |=> !state_q);

    p_preset_r11: assert property (@(posedge clk) disable iff (rst)
        (asy.set && !asy.clr) |=> state_q);

endmodule

// File: rtl/mc_outsel.sv
module mc_outsel #(
    parameter int NUM_OE = 2,
    parameter int OE_W   = 3
) (
    input  logic              q,
    input  logic              xor_in,
    input  logic              out_reg,
    input  logic              fb_reg,
    input  logic [OE_W-1:0]   oe_sel,
    input  logic [NUM_OE-1:0] oe_pin,
    input  logic              pt_oe,
    output logic              pad_o,
    output logic              pad_oe,
    output logic              fb_o
);
    localparam int OE_PIN0 = 2;
    localparam int OE_PT   = OE_PIN0 + NUM_OE;

    assign pad_o = out_reg ? q : xor_in;
    assign fb_o  = fb_reg  ? q : xor_in;

    always_comb begin
        pad_oe = 1'b0;
        if (oe_sel == OE_W'(1))          pad_oe = 1'b1;
        else if (oe_sel == OE_W'(OE_PT)) pad_oe = pt_oe;
        else begin
            for (int i = 0; i < NUM_OE; i++) begin
                if (oe_sel == OE_W'(OE_PIN0 + i)) pad_oe = oe_pin[i];
            end
        end
    end

endmodule

// File: rtl/mc_regout.sv
module mc_regout
    import mc_pkg::*;
#(
    parameter  int NUM_GCLK = 3,
    parameter  int NUM_OE   = 2,
    localparam int CSEL_W   = $clog2(NUM_GCLK + 1),
    localparam int OE_W     = $clog2(NUM_OE + 3)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                xor_in,
    input  logic                pt_d,
    input  logic                pad_in,
    input  logic                pt_k,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic                pt_ce,
    input  logic                gclr,
    input  logic                pt_ar,
    input  logic                pt_ap,
    input  logic [NUM_OE-1:0]   oe_pin,
    input  logic                pt_oe,
    input  logic [1:0]          cfg_dsrc,
    input  logic [2:0]          cfg_mode,
    input  logic [CSEL_W-1:0]   cfg_clk_sel,
    input  logic                cfg_ce_en,
    input  logic [1:0]          cfg_ar_sel,
    input  logic                cfg_ap_sel,
    input  logic                cfg_out_reg,
    input  logic                cfg_fb_reg,
    input  logic [OE_W-1:0]     cfg_oe_sel,
    output logic                pad_o,
    output logic                pad_oe,
    output logic                fb_o
);
    mc_clkev_t ev;
    mc_async_t asy;
    logic      q;

    mc_clkgate #(.NUM_GCLK(NUM_GCLK), .CSEL_W(CSEL_W)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .gclk    (gclk),
        .pt_clk  (pt_clk),
        .clk_sel (cfg_clk_sel),
        .ce_en   (cfg_ce_en),
        .pt_ce   (pt_ce),
        .ev      (ev)
    );

    mc_async u_async (
        .gclr   (gclr),
        .pt_ar  (pt_ar),
        .pt_ap  (pt_ap),
        .ar_sel (cfg_ar_sel),
        .ap_sel (cfg_ap_sel),
        .act    (asy)
    );

    mc_store u_store (
        .clk    (clk),
        .rst    (rst),
        .mode   (cfg_mode),
        .dsrc   (cfg_dsrc),
        .xor_in (xor_in),
        .pt_d   (pt_d),
        .pad_in (pad_in),
        .pt_k   (pt_k),
        .ev     (ev),
        .asy    (asy),
        .q      (q)
    );

    mc_outsel #(.NUM_OE(NUM_OE), .OE_W(OE_W)) u_out (
        .q       (q),
        .xor_in  (xor_in),
        .out_reg (cfg_out_reg),
        .fb_reg  (cfg_fb_reg),
        .oe_sel  (cfg_oe_sel),
        .oe_pin  (oe_pin),
        .pt_oe   (pt_oe),
        .pad_o   (pad_o),
        .pad_oe  (pad_oe),
        .fb_o    (fb_o)
    );

endmodule

// File: tb/test_mc_regout.sv
module test_mc_regout;
    logic       clk = 1'b0;
    logic       rst;
    logic       xor_in, pt_d, pad_in, pt_k;
    logic [2:0] gclk;
    logic       pt_clk, pt_ce, gclr, pt_ar, pt_ap, pt_oe;
    logic [1:0] oe_pin;
    logic [1:0] cfg_dsrc;
    logic [2:0] cfg_mode;
    logic [1:0] cfg_clk_sel;
    logic       cfg_ce_en;
    logic [1:0] cfg_ar_sel;
    logic       cfg_ap_sel, cfg_out_reg, cfg_fb_reg;
    logic [2:0] cfg_oe_sel;
    logic       pad_o, pad_oe, fb_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #5 clk = ~clk;

    mc_regout i_mc_regout (
        .clk(clk), .rst(rst), .xor_in(xor_in), .pt_d(pt_d), .pad_in(pad_in),
        .pt_k(pt_k), .gclk(gclk), .pt_clk(pt_clk), .pt_ce(pt_ce), .gclr(gclr),
        .pt_ar(pt_ar), .pt_ap(pt_ap), .oe_pin(oe_pin), .pt_oe(pt_oe),
        .cfg_dsrc(cfg_dsrc), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
        .cfg_ce_en(cfg_ce_en), .cfg_ar_sel(cfg_ar_sel), .cfg_ap_sel(cfg_ap_sel),
        .cfg_out_reg(cfg_out_reg), .cfg_fb_reg(cfg_fb_reg), .cfg_oe_sel(cfg_oe_sel),
        .pad_o(pad_o), .pad_oe(pad_oe), .fb_o(fb_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic set_lvl(input int idx, input logic v);
        if (idx < 3) gclk[idx] = v;
        else         pt_clk    = v;
    endtask

    task automatic pulse(input int idx);
        set_lvl(idx, 1'b1);
        tick();
        set_lvl(idx, 1'b0);
        tick();
    endtask

    task automatic force_q(input logic v);
        if (v) begin
            cfg_ap_sel = 1'b1; pt_ap = 1'b1; tick(); pt_ap = 1'b0; cfg_ap_sel = 1'b0;
        end else begin
            cfg_ar_sel = 2'd2; pt_ar = 1'b1; tick(); pt_ar = 1'b0; cfg_ar_sel = 2'd0;
        end
    endtask

    // Expected next state from the mode tables in the requirements.
    function automatic logic model(input int m, input logic q, input logic a, input logic b);
        case (m)
            0: return a;
            1: return a ? ~q : q;
            2: case ({a, b}) 2'b10: return 1'b1; 2'b01: return 1'b0;
                             2'b11: return ~q;   default: return q; endcase
            default: case ({a, b}) 2'b10: return 1'b1; 2'b01: return 1'b0;
                                   default: return q; endcase
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; xor_in = 0; pt_d = 0; pad_in = 0; pt_k = 0; gclk = '0;
        pt_clk = 0; pt_ce = 0; gclr = 0; pt_ar = 0; pt_ap = 0; pt_oe = 0; oe_pin = '0;
        cfg_dsrc = 0; cfg_mode = 0; cfg_clk_sel = 0; cfg_ce_en = 0; cfg_ar_sel = 0;
        cfg_ap_sel = 0; cfg_out_reg = 1; cfg_fb_reg = 1; cfg_oe_sel = 3'd1;
        #1;
        tick(); tick(); tick();
        rst = 1'b0;
        #1;
        chk("R1 reset pad", pad_o, 1'b0);
        chk("R1 reset fb", fb_o, 1'b0);

        // R3 R4 R5 R6: every mode, start state and operand pair
        for (int m = 0; m < 4; m++) begin
            for (int q0 = 0; q0 < 2; q0++) begin
                for (int ab = 0; ab < 4; ab++) begin
                    string tag;
                    tag = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
                    cfg_mode = 3'(m);
                    force_q(q0[0]);
                    xor_in = ab[1]; pt_k = ab[0];
                    tick();
                    chk({tag, " hold before edge"}, pad_o, q0[0]);
                    pulse(0);
                    chk({tag, " edge result"}, pad_o, model(m, q0[0], ab[1], ab[0]));
                end
            end
        end
        cfg_mode = 0; pt_k = 0;

        // R2: data source sweep
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 2; v++) begin
                cfg_dsrc = 2'(s);
                xor_in = ~v[0]; pt_d = ~v[0]; pad_in = ~v[0];
                if (s == 1)      pt_d   = v[0];
                else if (s == 2) pad_in = v[0];
                else             xor_in = v[0];
                pulse(1'b0 ? 1 : 0);
                chk("R2 data source", pad_o, v[0]);
            end
        end
        cfg_dsrc = 0; pt_d = 0; pad_in = 0;

        // R8: clock selection
        for (int s = 0; s < 4; s++) begin
            cfg_clk_sel = 2'(s);
            force_q(1'b0);
            xor_in = 1'b1;
            for (int o = 0; o < 4; o++) begin
                if (o != s) begin
                    pulse(o);
                    chk("R8 unselected clock ignored", pad_o, 1'b0);
                end
            end
            pulse(s);
            chk("R8 selected clock captures", pad_o, 1'b1);
        end

        // R9: clock enable
        cfg_clk_sel = 2'd1; cfg_ce_en = 1'b1;
        force_q(1'b0); xor_in = 1'b1; pt_ce = 1'b0;
        pulse(1);
        chk("R9 enable low blocks global edge", pad_o, 1'b0);
        pt_ce = 1'b1;
        pulse(1);
        chk("R9 enable high passes edge", pad_o, 1'b1);
        cfg_clk_sel = 2'd3; pt_ce = 1'b0;
        force_q(1'b0);
        pulse(3);
        chk("R9 enable unused on product-term clock", pad_o, 1'b1);
        cfg_ce_en = 1'b0; cfg_clk_sel = 2'd0;

        // R7: transparent latch
        cfg_mode = 3'd4;
        xor_in = 1'b0;
        force_q(1'b0);
        xor_in = 1'b1;
        #1 chk("R7 closed latch ignores data", pad_o, 1'b0);
        gclk[0] = 1'b1; xor_in = 1'b1;
        #1 chk("R7 open latch passes 1", pad_o, 1'b1);
        tick();
        xor_in = 1'b0;
        #1 chk("R7 open latch passes 0", pad_o, 1'b0);
        tick();
        xor_in = 1'b1;
        tick();
        gclk[0] = 1'b0; xor_in = 1'b0;
        #1 chk("R7 latch holds after close", pad_o, 1'b1);
        tick();
        chk("R7 latch still holds", pad_o, 1'b1);
        cfg_mode = 3'd0;

        // R10: clear source sweep, same-cycle effect and retained state
        for (int sel = 0; sel < 4; sel++) begin
            for (int g = 0; g < 2; g++) begin
                for (int p = 0; p < 2; p++) begin
                    logic e;
                    force_q(1'b1);
                    cfg_ar_sel = 2'(sel); gclr = g[0]; pt_ar = p[0];
                    e = ((sel & 1) != 0 && g != 0) || ((sel & 2) != 0 && p != 0) ? 1'b0 : 1'b1;
                    #1 chk("R10 clear immediate", pad_o, e);
                    tick();
                    gclr = 0; pt_ar = 0; cfg_ar_sel = 0;
                    tick();
                    chk("R10 clear retained", pad_o, e);
                end
            end
        end

        // R10 R11: clear beats preset, preset acts at once
        force_q(1'b0);
        cfg_ap_sel = 1'b1; pt_ap = 1'b1; cfg_ar_sel = 2'd2; pt_ar = 1'b1;
        #1 chk("R10 clear wins over preset", pad_o, 1'b0);
        tick();
        pt_ar = 1'b0;
        #1 chk("R11 preset immediate", pad_o, 1'b1);
        tick();
        pt_ap = 1'b0; cfg_ap_sel = 1'b0; cfg_ar_sel = 2'd0;
        tick();
        chk("R11 preset retained", pad_o, 1'b1);
        force_q(1'b0);
        pt_ap = 1'b1;
        #1 chk("R11 disabled preset no effect", pad_o, 1'b0);
        tick();
        chk("R11 disabled preset no effect later", pad_o, 1'b0);
        pt_ap = 1'b0;

        // R12: output and feedback selection
        for (int qv = 0; qv < 2; qv++) begin
            for (int xv = 0; xv < 2; xv++) begin
                for (int orr = 0; orr < 2; orr++) begin
                    for (int fr = 0; fr < 2; fr++) begin
                        force_q(qv[0]);
                        xor_in = xv[0]; cfg_out_reg = orr[0]; cfg_fb_reg = fr[0];
                        #1;
                        chk("R12 pad path", pad_o, orr[0] ? qv[0] : xv[0]);
                        chk("R12 feedback path", fb_o, fr[0] ? qv[0] : xv[0]);
                    end
                end
            end
        end
        cfg_out_reg = 1'b1; cfg_fb_reg = 1'b1;

        // R13: output enable source sweep
        for (int s = 0; s < 8; s++) begin
            for (int pins = 0; pins < 4; pins++) begin
                for (int pt = 0; pt < 2; pt++) begin
                    logic e;
                    cfg_oe_sel = 3'(s); oe_pin = 2'(pins); pt_oe = pt[0];
                    case (s)
                        1: e = 1'b1;
                        2: e = pins[0];
                        3: e = pins[1];
                        4: e = pt[0];
                        default: e = 1'b0;
                    endcase
                    #1 chk("R13 output enable", pad_oe, e);
                end
            end
        end
        cfg_oe_sel = 3'd1;

        // R1: reset from a set state
        force_q(1'b1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        #1 chk("R1 reset clears set state", pad_o, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule